// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a serial peripheral interface master that software drives through a small 32-bit register bus. Software queues words into a transmit FIFO, picks the clock polarity, phase and bit order, and then releases a hold-off bit. The controller then shifts the queued words out back to back and captures one received word per transmitted word into a receive FIFO. The word width (8, 16 or 32 bits), the FIFO depth, the serial clock divider and the number of slave selects are all fixed at build time.

Slave selects are active-low and come from a software register. In manual mode the register value drives the pins all the time. In automatic mode the pins are driven only while the shifter is busy and are otherwise all high. An internal loopback path feeds the outgoing serial data back into the receive sampler, so software can test the datapath and confirm its access byte order. Single-cycle event pulses (transmit drained, transmit write dropped, receive word dropped, mode fault) go to an external interrupt block.

The shifter is a three-state machine. ST_IDLE holds SCLK at the polarity level. ST_LEAD counts half a bit period and ends with the leading SCLK edge. ST_TRAIL counts the second half and ends with the trailing edge. The transitions are as follows. Start (ST_IDLE to ST_LEAD) happens when shifting is allowed and a word is queued. Half (ST_LEAD to ST_TRAIL) happens on the leading edge. Next-bit (ST_TRAIL to ST_LEAD) happens on a trailing edge that is not the last one of the word. Reload (ST_TRAIL to ST_LEAD) happens on the last trailing edge when another word is queued and shifting is still allowed. Stop (ST_TRAIL to ST_IDLE) happens on the last trailing edge otherwise.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control register reads 0x100 (hold-off set), the status register reads 0x05, the select register reads all ones, ss_n is all ones and sclk is 0.
- R2: Control register (offset 0x60) bits: 0 loopback, 1 enable, 2 master, 3 polarity, 4 phase, 5 transmit FIFO clear, 6 receive FIFO clear, 7 manual select, 8 hold-off, 9 LSB first. Every bit except 5 and 6 reads back exactly as written. Bits 5 and 6 read as 0, and writing 1 to either one empties that FIFO.
- R3: Status register (offset 0x64) bits: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full, 4 mode fault.
- R4: No word leaves the transmit FIFO and sclk does not toggle while hold-off is set or enable is clear.
- R5: Each word takes 2*CLK_DIV*WORD_W clock cycles. Queued words follow each other with no gap. ev_tx_empty is high in the cycle after the last trailing edge, when the FIFO is empty. Counting from the clock edge that clears hold-off, ev_tx_empty is first high after 1+2*CLK_DIV*WORD_W*N edges for N queued words.
- R6: sclk idles at the polarity bit. With phase 0, mosi is valid before the leading edge and is sampled on it. With phase 1, mosi changes on the leading edge and is sampled on the trailing edge. Bits go out MSB first, or LSB first when bit 9 is set.
- R7: Writes to offset 0x68 queue the low WORD_W bits. Reads of offset 0x6C pop a word, zero-extended above WORD_W. Received bits come from miso, or from mosi when loopback is set.
- R8: A write to a full transmit FIFO is dropped and ev_tx_overflow pulses in the next cycle.
- R9: A received word that arrives while the receive FIFO is full is dropped and ev_rx_overrun pulses in the next cycle.
- R10: Select register (offset 0x70): in manual mode ss_n follows it one cycle after it changes. In automatic mode ss_n equals it while shifting and is all ones otherwise.
- R11: With enable set, master clear, hold-off clear and a word queued, ev_mode_fault pulses once, status bit 4 is set until the next control write, and nothing shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at offset 0x6C) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| ev_tx_empty | output | 1 | Pulse: transmit FIFO drained and last word finished |
| ev_tx_overflow | output | 1 | Pulse: write to full transmit FIFO dropped |
| ev_rx_overrun | output | 1 | Pulse: received word dropped, receive FIFO full |
| ev_mode_fault | output | 1 | Pulse: shifting requested without master mode |

## Verification
Register reads are combinational, so the bench samples reg_rdata in the low half of the strobe cycle. The select pins and every event pulse are registered, so they are due one edge after their cause. The bench samples them just after that edge, or counts the pulses at each rising edge. The drain event is due exactly 1+2*CLK_DIV*WORD_W*N edges after the edge that clears hold-off, and the bench counts edges from that write to check the figure. Serial bits are checked at each sampling edge of sclk, which is chosen by polarity and phase, across every mode and bit-order combination.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_STAT = 8'h64;
    localparam logic [7:0] OFS_TXD  = 8'h68;
    localparam logic [7:0] OFS_RXD  = 8'h6C;
    localparam logic [7:0] OFS_SSEL = 8'h70;

    localparam int CB_LOOP = 0;
    localparam int CB_EN   = 1;
    localparam int CB_MSTR = 2;
    localparam int CB_CPOL = 3;
    localparam int CB_CPHA = 4;
    localparam int CB_TCLR = 5;
    localparam int CB_RCLR = 6;
    localparam int CB_MAN  = 7;
    localparam int CB_HOLD = 8;
    localparam int CB_LSB  = 9;

    localparam logic [9:0] CTRL_STORE_MASK = 10'h39F;
    localparam logic [9:0] CTRL_RESET      = 10'h100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } shift_state_e;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clr) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_host_pkg::*;
#(
    parameter int W       = 8,
    parameter int CLK_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_ok,
    input  logic         cpol_i,
    input  logic         cpha_i,
    input  logic         lsb_i,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_word,
    input  logic         miso_i,
    output logic         tx_pop,
    output logic         sclk,
    output logic         mosi,
    output logic         busy,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         done_ev
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(W);

    shift_state_e     state, state_nxt;
    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic [W-1:0]     tx_sr, rx_sr, rx_shifted;
    logic             cpha_q, lsb_q;
    logic             half_done, last_bit, load;

    assign half_done  = (div_cnt == DIV_W'(CLK_DIV - 1));
    assign last_bit   = (bit_cnt == BIT_W'(W - 1));
    assign rx_shifted = lsb_q ? {miso_i, rx_sr[W-1:1]} : {rx_sr[W-2:0], miso_i};
    assign rx_push    = (state == ST_TRAIL) && half_done && last_bit;
    assign rx_word    = cpha_q ? rx_shifted : rx_sr;
    assign load       = run_ok && tx_avail &&
                        ((state == ST_IDLE) || rx_push);
    assign tx_pop     = load;
    assign busy       = (state != ST_IDLE);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = load ? ST_LEAD : ST_IDLE;
            ST_LEAD:  state_nxt = half_done ? ST_TRAIL : ST_LEAD;
            ST_TRAIL: begin
                if (!half_done)      state_nxt = ST_TRAIL;
                else if (!last_bit)  state_nxt = ST_LEAD;
                else if (load)       state_nxt = ST_LEAD;
                else                 state_nxt = ST_IDLE;
            end
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            cpha_q  <= 1'b0;
            lsb_q   <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            done_ev <= 1'b0;
        end else begin
            done_ev <= rx_push && !load;
            if (load) begin
                cpha_q  <= cpha_i;
                lsb_q   <= lsb_i;
                sclk    <= cpol_i;
                div_cnt <= '0;
                bit_cnt <= '0;
                if (!cpha_i) begin
                    mosi  <= lsb_i ? tx_word[0] : tx_word[W-1];
                    tx_sr <= lsb_i ? (tx_word >> 1) : (tx_word << 1);
                end else begin
                    tx_sr <= tx_word;
                end
            end else begin
                unique case (state)
                    ST_IDLE: sclk <= cpol_i;
                    ST_LEAD: begin
                        if (half_done) begin
                            sclk    <= ~sclk;
                            div_cnt <= '0;
                            if (!cpha_q) begin
                                rx_sr <= rx_shifted;
                            end else begin
                                mosi  <= lsb_q ? tx_sr[0] : tx_sr[W-1];
                                tx_sr <= lsb_q ? (tx_sr >> 1) : (tx_sr << 1);
                            end
                        end else begin
                            div_cnt <= div_cnt + 1'b1;
                        end
                    end
                    ST_TRAIL: begin
                        if (half_done) begin
                            sclk    <= ~sclk;
                            div_cnt <= '0;
                            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                            if (cpha_q) begin
                                rx_sr <= rx_shifted;
                            end else if (!last_bit) begin
                                mosi  <= lsb_q ? tx_sr[0] : tx_sr[W-1];
                                tx_sr <= lsb_q ? (tx_sr >> 1) : (tx_sr << 1);
                            end
                        end else begin
                            div_cnt <= div_cnt + 1'b1;
                        end
                    end
                    default: sclk <= cpol_i;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_DIV    = 2,
    parameter int NUM_SS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              ev_tx_empty,
    output logic              ev_tx_overflow,
    output logic              ev_rx_overrun,
    output logic              ev_mode_fault
);
    logic [9:0]        ctrl_q;
    logic [NUM_SS-1:0] ssel_q;
    logic              mf_flag;

    logic ctrl_wr, ssel_wr, tx_wr, rx_rd;
    logic tx_clr, rx_clr;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic tx_pop, rx_push, eng_busy, run_ok, mf_cond, miso_eff;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;

    assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
    assign ssel_wr = reg_wr && (reg_addr == OFS_SSEL);
    assign tx_wr   = reg_wr && (reg_addr == OFS_TXD);
    assign rx_rd   = reg_rd && (reg_addr == OFS_RXD);
    assign tx_clr  = ctrl_wr && reg_wdata[CB_TCLR];
    assign rx_clr  = ctrl_wr && reg_wdata[CB_RCLR];

    assign run_ok   = ctrl_q[CB_EN] && ctrl_q[CB_MSTR] && !ctrl_q[CB_HOLD];
    assign mf_cond  = ctrl_q[CB_EN] && !ctrl_q[CB_MSTR] && !ctrl_q[CB_HOLD] && !tx_empty;
    assign miso_eff = ctrl_q[CB_LOOP] ? mosi : miso;

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_wr), .push_data(reg_wdata[WORD_W-1:0]),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_rd), .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_shift_engine #(.W(WORD_W), .CLK_DIV(CLK_DIV)) u_engine (
        .clk(clk), .rst_n(rst_n), .run_ok(run_ok),
        .cpol_i(ctrl_q[CB_CPOL]), .cpha_i(ctrl_q[CB_CPHA]), .lsb_i(ctrl_q[CB_LSB]),
        .tx_avail(!tx_empty), .tx_word(tx_head), .miso_i(miso_eff),
        .tx_pop(tx_pop), .sclk(sclk), .mosi(mosi), .busy(eng_busy),
        .rx_push(rx_push), .rx_word(rx_word), .done_ev(ev_tx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q         <= CTRL_RESET;
            ssel_q         <= '1;
            mf_flag        <= 1'b0;
            ev_tx_overflow <= 1'b0;
            ev_rx_overrun  <= 1'b0;
            ev_mode_fault  <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= reg_wdata[9:0] & CTRL_STORE_MASK;
            if (ssel_wr) ssel_q <= reg_wdata[NUM_SS-1:0];
            if (ctrl_wr)      mf_flag <= 1'b0;
            else if (mf_cond) mf_flag <= 1'b1;
            ev_tx_overflow <= tx_wr && tx_full;
            ev_rx_overrun  <= rx_push && rx_full;
            ev_mode_fault  <= mf_cond && !mf_flag && !ctrl_wr;
        end
    end

    // one registered driver per select line
    for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ss_n[g] <= 1'b1;
            else        ss_n[g] <= (ctrl_q[CB_MAN] || eng_busy) ? ssel_q[g] : 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {22'd0, ctrl_q};
            OFS_STAT: reg_rdata = {27'd0, mf_flag, tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:  reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
            OFS_SSEL: reg_rdata = 32'(ssel_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              hold,
    input logic              cpol,
    input logic              manual,
    input logic              tx_wr,
    input logic              tx_full,
    input logic              rx_push,
    input logic              rx_full,
    input logic              sclk,
    input logic [NUM_SS-1:0] ss_n,
    input logic              ev_tx_empty,
    input logic              ev_tx_overflow,
    input logic              ev_rx_overrun
);
    p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hold) |=> !busy);

    p_drain_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_empty |-> !busy);

    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

    p_tx_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full) |=> ev_tx_overflow);

    p_rx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ev_rx_overrun);

    p_auto_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && !busy) |=> (ss_n == '1));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .hold(ctrl_q[8]),
    .cpol(ctrl_q[3]), .manual(ctrl_q[7]), .tx_wr(tx_wr), .tx_full(tx_full),
    .rx_push(rx_push), .rx_full(rx_full), .sclk(sclk), .ss_n(ss_n),
    .ev_tx_empty(ev_tx_empty), .ev_tx_overflow(ev_tx_overflow),
    .ev_rx_overrun(ev_rx_overrun)
);

// File: tb/tb_spi_host_ctrl.sv
`timescale 1ns/1ps
module tb_spi_host_ctrl;
    localparam int W = 8, DIV = 2, DEPTH = 16, NSS = 4;
    localparam int WORD_CYC = 2 * DIV * W;
    localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                           A_RXD = 8'h6C, A_SSEL = 8'h70;
    localparam logic [31:0] C_LOOP = 32'h1, C_EN = 32'h2, C_MST = 32'h4,
        C_CPOL = 32'h8, C_CPHA = 32'h10, C_TCLR = 32'h20, C_RCLR = 32'h40,
        C_MAN = 32'h80, C_HOLD = 32'h100, C_LSB = 32'h200;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0, miso = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic sclk, mosi;
    logic [NSS-1:0] ss_n;
    logic ev_tx_empty, ev_tx_overflow, ev_rx_overrun, ev_mode_fault;

    int n_checks = 0, n_fail = 0;
    int n_ovf = 0, n_ovr = 0, n_mf = 0, tog = 0, capn = 0;
    logic [31:0] cap = 0;
    logic mon_en = 0, mon_cpol = 0, mon_cpha = 0;

    spi_host_ctrl #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV), .NUM_SS(NSS)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .ev_tx_empty(ev_tx_empty), .ev_tx_overflow(ev_tx_overflow),
        .ev_rx_overrun(ev_rx_overrun), .ev_mode_fault(ev_mode_fault)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) begin
            if (ev_tx_overflow) n_ovf <= n_ovf + 1;
            if (ev_rx_overrun)  n_ovr <= n_ovr + 1;
            if (ev_mode_fault)  n_mf  <= n_mf + 1;
        end
    end

    // serial monitor: samples mosi on the sampling edge picked by mode
    always @(sclk) begin
        tog = tog + 1;
        if (mon_en && ((sclk == 1'b1) == (mon_cpol == mon_cpha))) begin
            cap  = {cap[30:0], mosi};
            capn = capn + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic wait_drain(output int cnt);
        cnt = 0;
        while (!ev_tx_empty && cnt < 4000) begin
            @(posedge clk); #1;
            cnt++;
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, mode;
        int cnt, n0, t0;
        logic [7:0] w;
        repeat (3) @(posedge clk);
        #1; chk("R1 sclk", {31'd0, sclk}, 0);
        chk("R1 ss_n", {28'd0, ss_n}, 32'hF);
        @(negedge clk) rst_n = 1;
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h100);
        rd(A_STAT, v); chk("R1 status", v, 32'h05);
        rd(A_SSEL, v); chk("R1 ssel", v, 32'hF);

        // R2 readback, self-clearing clear bits
        wr(A_CTRL, 32'h3FF); rd(A_CTRL, v); chk("R2 clear bits read 0", v, 32'h39F);
        wr(A_CTRL, C_LOOP);  rd(A_CTRL, v); chk("R2 loopback readback", v, 32'h1);
        wr(A_CTRL, C_HOLD);
        wr(A_TXD, 1); wr(A_TXD, 2); wr(A_TXD, 3);
        rd(A_STAT, v); chk("R3 tx not empty", v, 32'h01);
        wr(A_CTRL, C_HOLD | C_TCLR);
        rd(A_STAT, v); chk("R2 tx clear", v, 32'h05);
        rd(A_CTRL, v); chk("R2 clear self-clears", v, C_HOLD);

        // R4 hold-off and enable gating
        wr(A_CTRL, C_EN | C_MST | C_HOLD); wr(A_TXD, 8'h5A);
        t0 = tog; repeat (100) @(posedge clk); #1;
        chk("R4 hold no toggle", tog - t0, 0);
        wr(A_CTRL, C_MST); t0 = tog; repeat (100) @(posedge clk); #1;
        chk("R4 disabled no toggle", tog - t0, 0);
        rd(A_STAT, v); chk("R4 word kept", v, 32'h01);
        wr(A_CTRL, C_HOLD | C_TCLR | C_RCLR);

        // R5/R6/R7 sweep of polarity, phase, bit order in loopback
        for (int m = 0; m < 8; m++) begin
            mode = (m[0] ? C_CPOL : 0) | (m[1] ? C_CPHA : 0) | (m[2] ? C_LSB : 0);
            for (int k = 0; k < 4; k++) begin
                w = (k == 0) ? 8'h80 : (k == 1) ? 8'h01 : 8'((k * 91 + m * 17 + 44));
                wr(A_CTRL, C_LOOP | C_EN | C_MST | C_HOLD | mode);
                wr(A_TXD, {24'hC3A50F, w});
                repeat (4) @(posedge clk); #1;
                chk("R6 idle level", {31'd0, sclk}, {31'd0, m[0]});
                mon_cpol = m[0]; mon_cpha = m[1]; mon_en = 1; n0 = capn;
                wr(A_CTRL, C_LOOP | C_EN | C_MST | mode);
                wait_drain(cnt);
                mon_en = 0;
                chk("R5 word duration", cnt, 1 + WORD_CYC);
                chk("R6 bit count", capn - n0, W);
                chk("R6 bit order", {24'd0, cap[7:0]}, {24'd0, m[2] ? rev8(w) : w});
                rd(A_RXD, v); chk("R7 loopback data zero-extended", v, {24'd0, w});
            end
        end

        // R7 external miso
        wr(A_CTRL, C_EN | C_MST | C_HOLD); miso = 1; wr(A_TXD, 0);
        wr(A_CTRL, C_EN | C_MST); wait_drain(cnt);
        rd(A_RXD, v); chk("R7 miso ones", v, 32'hFF);
        wr(A_CTRL, C_EN | C_MST | C_HOLD); miso = 0; wr(A_TXD, 32'hFF);
        wr(A_CTRL, C_EN | C_MST); wait_drain(cnt);
        rd(A_RXD, v); chk("R7 miso zeros", v, 32'h00);

        // R8 transmit full, R5 back-to-back
        wr(A_CTRL, C_LOOP | C_EN | C_MST | C_HOLD);
        for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(i * 7 + 3));
        rd(A_STAT, v); chk("R3 tx full", v, 32'h09);
        chk("R8 no early overflow", n_ovf, 0);
        wr(A_TXD, 32'hEE); @(posedge clk); #1;
        chk("R8 overflow pulse", n_ovf, 1);
        wr(A_CTRL, C_LOOP | C_EN | C_MST); wait_drain(cnt);
        chk("R5 back-to-back duration", cnt, 1 + WORD_CYC * DEPTH);
        rd(A_STAT, v); chk("R3 rx full tx empty", v, 32'h06);
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_RXD, v); chk("R8 kept words", v, 32'((i * 7 + 3) & 8'hFF));
        end
        rd(A_STAT, v); chk("R8 dropped word absent", v, 32'h05);
        chk("R9 no overrun yet", n_ovr, 0);

        // R9 receive overrun
        wr(A_CTRL, C_LOOP | C_EN | C_MST | C_HOLD);
        for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(i + 100));
        wr(A_CTRL, C_LOOP | C_EN | C_MST); wait_drain(cnt);
        wr(A_CTRL, C_LOOP | C_EN | C_MST | C_HOLD); wr(A_TXD, 32'h77);
        wr(A_CTRL, C_LOOP | C_EN | C_MST); wait_drain(cnt);
        @(posedge clk); #1;
        chk("R9 overrun pulse", n_ovr, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_RXD, v); chk("R9 kept words", v, 32'(i + 100));
        end
        rd(A_STAT, v); chk("R9 extra dropped", v, 32'h05);

        // R10 manual and automatic selects
        wr(A_CTRL, C_MAN | C_EN | C_MST | C_HOLD); wr(A_SSEL, 32'hB);
        @(posedge clk); #1; chk("R10 manual", {28'd0, ss_n}, 32'hB);
        wr(A_CTRL, C_LOOP | C_EN | C_MST | C_HOLD); wr(A_SSEL, 32'hD);
        @(posedge clk); #1; chk("R10 auto idle", {28'd0, ss_n}, 32'hF);
        wr(A_TXD, 32'h42); wr(A_CTRL, C_LOOP | C_EN | C_MST);
        repeat (10) @(posedge clk); #1;
        chk("R10 auto active", {28'd0, ss_n}, 32'hD);
        wait_drain(cnt); @(posedge clk); #1;
        chk("R10 auto released", {28'd0, ss_n}, 32'hF);
        rd(A_RXD, v); chk("R7 loopback 0x42", v, 32'h42);

        // R11 mode fault
        wr(A_CTRL, C_EN | C_HOLD); wr(A_TXD, 32'h99);
        repeat (2) @(posedge clk); #1; t0 = tog;
        wr(A_CTRL, C_EN); repeat (40) @(posedge clk); #1;
        chk("R11 one pulse", n_mf, 1);
        chk("R11 no shifting", tog - t0, 0);
        rd(A_STAT, v); chk("R11 status flag", v, 32'h11);
        wr(A_CTRL, C_HOLD | C_TCLR | C_RCLR);
        rd(A_STAT, v); chk("R11 flag cleared", v, 32'h05);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule